// File: doc/BRIEF.md
# Page-Bounded Write Chunker

This block takes a byte-write request, given as a start address and a byte length, and turns it into a sequence of program descriptors. No descriptor ever spans a 256-byte page boundary. Each descriptor gives the flash address, the offset into the caller's source buffer and the byte count. Descriptors go out one at a time to a downstream program engine under a valid/acknowledge handshake.

A request that fits inside one page becomes a single descriptor. A longer request becomes a leading partial piece up to the end of the first page, then whole pages, then a tail piece if any bytes remain. When the final descriptor is acknowledged, the block raises a one-cycle completion pulse. The block moves no data. It only describes the pieces.

Top module: `page_split`

## Requirements
- R1: While reset is asserted and after it is released, `chunk_valid`, `done` and `busy` are 0.
- R2: A request (`req_valid` high) is taken only when `busy` is 0. A request presented while `busy` is 1 does not change the descriptor and does not start a new sequence.
- R3: For every descriptor, `chunk_addr[7:0] + chunk_len` is at most 256, so a descriptor never crosses a page boundary. The page is made of address bits [7:0].
- R4: A request whose bytes all lie within one page produces exactly one descriptor: `chunk_addr` equal to the start address, `chunk_offset` 0 and `chunk_len` equal to the request length.
- R5: A request that spans pages has a first descriptor whose length is 256 minus the start address bits [7:0].
- R6: After the first descriptor, descriptors of length 256 are issued while at least 256 bytes remain.
- R7: A remainder between 1 and 255 is issued as the final descriptor. When the remainder is zero, nothing follows the last full page.
- R8: Each new descriptor's address and offset equal those of the previous descriptor plus its length. The first offset is 0, and the lengths add up to the request length.
- R9: A descriptor holds its address, offset and length unchanged from the cycle it appears until the cycle it is acknowledged.
- R10: A request of length 0 issues no descriptor and pulses `done` in the next cycle.
- R11: `done` is high for one cycle, in the cycle after the last descriptor's acknowledge. A new request can be taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New write request present |
| req_addr | input | ADDR_W | Start flash byte address |
| req_len | input | LEN_W | Request length in bytes |
| busy | output | 1 | Sequence in progress; requests are ignored |
| chunk_valid | output | 1 | Descriptor present |
| chunk_addr | output | ADDR_W | Descriptor flash address |
| chunk_offset | output | LEN_W | Descriptor offset into source buffer |
| chunk_len | output | PAGE_SHIFT+1 | Descriptor byte count |
| chunk_ack | input | 1 | Downstream accepted the descriptor |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two things can happen in the same cycle: the last descriptor's acknowledge, and the arrival of the next request. The bench holds `req_valid` high while it acknowledges a final descriptor. That request must be ignored on the acknowledge edge, because the block is still busy. It must then be taken on the edge where `done` is high, and its first descriptor must carry the new address with offset 0. A separate check raises `req_valid` in the middle of a multi-page sequence and confirms that the pending descriptor does not move.

// File: rtl/page_split.sv
module page_split #(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int PAGE_SHIFT = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [LEN_W-1:0]      req_len,
  output logic                  busy,
  output logic                  chunk_valid,
  output logic [ADDR_W-1:0]     chunk_addr,
  output logic [LEN_W-1:0]      chunk_offset,
  output logic [PAGE_SHIFT:0]   chunk_len,
  input  logic                  chunk_ack,
  output logic                  done
);
  localparam int CL_W = PAGE_SHIFT + 1;
  localparam logic [CL_W-1:0] PAGE = CL_W'(1 << PAGE_SHIFT);

  logic              active, done_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  cur_off, remain;
  logic [CL_W-1:0]   room, take;
  logic              fits;

  assign room = PAGE - {1'b0, cur_addr[PAGE_SHIFT-1:0]};
  assign fits = remain <= LEN_W'(room);
  assign take = fits ? remain[CL_W-1:0] : room;

  assign busy         = active;
  assign chunk_valid  = active;
  assign chunk_addr   = cur_addr;
  assign chunk_offset = cur_off;
  assign chunk_len    = take;
  assign done         = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      done_q   <= 1'b0;
      cur_addr <= '0;
      cur_off  <= '0;
      remain   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (req_valid) begin
          if (req_len == '0) begin
            done_q <= 1'b1;
          end else begin
            active   <= 1'b1;
            cur_addr <= req_addr;
            cur_off  <= '0;
            remain   <= req_len;
          end
        end
      end else if (chunk_ack) begin
        cur_addr <= cur_addr + ADDR_W'(take);
        cur_off  <= cur_off + LEN_W'(take);
        remain   <= remain - LEN_W'(take);
        if (fits) begin
          active <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/page_split_chk.sv
module page_split_chk #(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int PAGE_SHIFT = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                chunk_valid,
  input logic [ADDR_W-1:0]   chunk_addr,
  input logic [LEN_W-1:0]    chunk_offset,
  input logic [PAGE_SHIFT:0] chunk_len,
  input logic                chunk_ack,
  input logic                busy,
  input logic                done
);
  p_no_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid |-> (int'(chunk_addr[PAGE_SHIFT-1:0]) + int'(chunk_len)) <= (1 << PAGE_SHIFT));

  p_nonzero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid |-> chunk_len != '0);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid && !chunk_ack |=> chunk_valid && $stable(chunk_addr)
                                  && $stable(chunk_offset) && $stable(chunk_len));

  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid && chunk_ack |=> !chunk_valid
      || (chunk_addr == $past(chunk_addr) + ADDR_W'($past(chunk_len))));

  p_off_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid && chunk_ack |=> !chunk_valid
      || (chunk_offset == $past(chunk_offset) + LEN_W'($past(chunk_len))));

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !chunk_valid && !busy);
endmodule

bind page_split page_split_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_SHIFT(PAGE_SHIFT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .chunk_valid(chunk_valid), .chunk_addr(chunk_addr),
  .chunk_offset(chunk_offset), .chunk_len(chunk_len), .chunk_ack(chunk_ack),
  .busy(busy), .done(done)
);

// File: tb/page_split_tb.sv
module page_split_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic        chunk_ack = 1'b0;
  logic        busy, chunk_valid, done;
  logic [23:0] chunk_addr;
  logic [15:0] chunk_offset;
  logic [8:0]  chunk_len;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  page_split u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .busy(busy), .chunk_valid(chunk_valid),
    .chunk_addr(chunk_addr), .chunk_offset(chunk_offset), .chunk_len(chunk_len),
    .chunk_ack(chunk_ack), .done(done)
  );

  // {addr, len, chunk count, first len, last len}
  localparam logic [79:0] VEC [8] = '{
    {24'h000010, 16'h0020, 8'd1, 16'd32,  16'd32},
    {24'h0000F0, 16'h0020, 8'd2, 16'd16,  16'd16},
    {24'h000100, 16'h0300, 8'd3, 16'd256, 16'd256},
    {24'h0001F0, 16'h0310, 8'd4, 16'd16,  16'd256},
    {24'h0012C0, 16'h0250, 8'd4, 16'd64,  16'd16},
    {24'h000000, 16'h0100, 8'd1, 16'd256, 16'd256},
    {24'h0000FF, 16'h0002, 8'd2, 16'd1,   16'd1},
    {24'h000010, 16'h00F0, 8'd1, 16'd240, 16'd240}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [23:0] a, input logic [15:0] l,
                         input int n, input int f, input int t);
    logic [23:0] ea;
    logic [15:0] eo;
    int el;
    @(negedge clk); req_valid = 1'b1; req_addr = a; req_len = l;
    @(negedge clk); req_valid = 1'b0;
    ea = a; eo = '0;
    for (int i = 0; i < n; i++) begin
      el = (i == 0) ? f : (i == n - 1) ? t : 256;
      chk("R2 valid", 32'(chunk_valid), 32'd1);
      chk("R8 addr", 32'(chunk_addr), 32'(ea));
      chk("R8 offset", 32'(chunk_offset), 32'(eo));
      chk(i == 0 ? (n == 1 ? "R4 len" : "R5 len") : (i == n - 1 ? "R7 len" : "R6 len"),
          32'(chunk_len), 32'(el));
      chk("R3 bound", 32'(int'(chunk_addr[7:0]) + int'(chunk_len) <= 256), 32'd1);
      if (i % 2 == 1) begin
        @(negedge clk);
        chk("R9 hold addr", 32'(chunk_addr), 32'(ea));
        chk("R9 hold len", 32'(chunk_len), 32'(el));
      end
      chunk_ack = 1'b1;
      @(negedge clk); chunk_ack = 1'b0;
      ea = ea + 24'(el); eo = eo + 16'(el);
    end
    chk("R8 total", 32'(eo), 32'(l));
    chk("R11 done", 32'(done), 32'd1);
    chk("R7 no extra", 32'(chunk_valid), 32'd0);
    @(negedge clk);
    chk("R11 pulse", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(chunk_valid), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 valid", 32'(chunk_valid), 32'd0);

    for (int v = 0; v < 8; v++)
      run_vec(VEC[v][79:56], VEC[v][55:40], int'(VEC[v][39:32]),
              int'(VEC[v][31:16]), int'(VEC[v][15:0]));

    // R10: zero length
    @(negedge clk); req_valid = 1'b1; req_addr = 24'h000123; req_len = 16'd0;
    @(negedge clk); req_valid = 1'b0;
    chk("R10 done", 32'(done), 32'd1);
    chk("R10 no chunk", 32'(chunk_valid), 32'd0);
    @(negedge clk);
    chk("R10 pulse", 32'(done), 32'd0);
    chk("R10 still idle", 32'(chunk_valid), 32'd0);

    // R2: request mid-sequence is ignored
    @(negedge clk); req_valid = 1'b1; req_addr = 24'h0000F0; req_len = 16'h0020;
    @(negedge clk); req_addr = 24'h004000; req_len = 16'h0008;
    @(negedge clk); req_valid = 1'b0;
    chk("R2 addr kept", 32'(chunk_addr), 32'h0000F0);
    chk("R2 len kept", 32'(chunk_len), 32'd16);
    chunk_ack = 1'b1;
    @(negedge clk); chunk_ack = 1'b0;
    chk("R2 second addr", 32'(chunk_addr), 32'h000100);
    // R11: final ack and a waiting request in the same cycle
    chunk_ack = 1'b1; req_valid = 1'b1; req_addr = 24'h000500; req_len = 16'h0008;
    @(negedge clk); chunk_ack = 1'b0;
    chk("R11 done on final", 32'(done), 32'd1);
    chk("R2 not taken while busy", 32'(chunk_valid), 32'd0);
    @(negedge clk); req_valid = 1'b0;
    chk("R11 taken in done cycle", 32'(chunk_valid), 32'd1);
    chk("R11 new addr", 32'(chunk_addr), 32'h000500);
    chk("R11 new offset", 32'(chunk_offset), 32'd0);
    chk("R4 new len", 32'(chunk_len), 32'd8);
    chunk_ack = 1'b1;
    @(negedge clk); chunk_ack = 1'b0;
    chk("R11 done again", 32'(done), 32'd1);
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule